// File: doc/BRIEF.md
# Least-recently-used victim checker for one cache set

This block watches the victim choices of a cache set with a parameterized number of ways and flags any eviction that is not least-recently-used. It does not keep an age for every way. It picks one way to watch and keeps one "used since" flag for each of the other ways. The watched index is taken from a free select input on the first clock after reset. Holding that input unconstrained in a formal run, or sweeping it in simulation, covers every way.

An access to the watched way clears all flags. An access to any other way sets that way's flag. When the design names the watched way as its victim, every other way must have been touched since the watched way was last touched. If one has not, the watched way was not the oldest and the error bit rises. The error stays high until the next reset. The block is placed beside the replacement logic and sees only its access and victim strobes. It does not touch the cache data.

Top module: `lru_victim_watch`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `err` is 0.
- R2: On the first rising clock edge with `rst_n` high, the watched index is taken from `watch_sel` and held until the next reset. When `WAYS` is not a power of two, a select value of `WAYS` or above is folded to `watch_sel - WAYS`.
- R3: During that first cycle after reset (the arming cycle), the access and victim inputs have no effect on the flags or on `err`.
- R4: After arming, an access (`acc_vld`=1) to an in-range way other than the watched way marks that way as used. The watched way's own flag position is never marked.
- R5: After arming, an access to the watched way clears the used mark of every other way.
- R6: After arming, a victim strobe (`vic_vld`=1) naming the watched way while any other way is unmarked sets `err` on the following clock edge.
- R7: A victim strobe on the watched way when every other way is marked leaves `err` at 0. A victim strobe naming any other way never raises `err`.
- R8: When a victim strobe and an access arrive in the same cycle, the victim is judged against the marks held before that cycle's access is applied.
- R9: Once set, `err` stays at 1 until `rst_n` is driven low.
- R10: An access or victim index of `WAYS` or above has no effect on the marks or on `err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| watch_sel | input | IDX_W | Free select that picks the watched way, sampled once after reset |
| acc_vld | input | 1 | An access to a way happens this cycle |
| acc_idx | input | IDX_W | Way index of the access |
| vic_vld | input | 1 | The design names a victim this cycle |
| vic_idx | input | IDX_W | Way index of the victim |
| err | output | 1 | Sticky flag: a non-least-recently-used eviction was seen |

## Verification
The bench builds two copies side by side. One has `WAYS`=4, a power of two, where the select maps straight through. The other has `WAYS`=3, which brings in the folding of select values and an index of 3 that lies outside the set. With four ways, every combination of marked ways can be swept for every watched way. That sweep puts each victim outcome and the sticky error within reach in a few hundred cycles. Directed sequences cover the arming cycle, a clear followed by a refill, and a victim strobe arriving together with an access. A long pseudo-random run compares both copies against an arithmetic model of the marks.

// File: rtl/lru_watch_pkg.sv
package lru_watch_pkg;

   typedef enum logic {
      PH_IDLE  = 1'b0,
      PH_ARMED = 1'b1
   } watch_phase_e;

   function automatic int unsigned idx_width(input int unsigned ways);
      return (ways > 1) ? $clog2(ways) : 1;
   endfunction

endpackage

// File: rtl/lru_watch_latch.sv
module lru_watch_latch
   import lru_watch_pkg::*;
#(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] sel,
   output logic             armed,
   output logic [IDX_W-1:0] watch_idx,
   output logic [WAYS-1:0]  watch_oh
);

   localparam int unsigned SPAN = 1 << IDX_W;

   watch_phase_e     phase_q;
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] folded;

   generate
      if (SPAN == WAYS) begin : g_direct
         assign folded = sel;
      end else begin : g_fold
         assign folded = (sel >= IDX_W'(WAYS)) ? (sel - IDX_W'(WAYS)) : sel;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         idx_q   <= '0;
      end else if (phase_q == PH_IDLE) begin
         phase_q <= PH_ARMED;
         idx_q   <= folded;
      end
   end

   assign armed     = (phase_q == PH_ARMED);
   assign watch_idx = idx_q;

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_oh
         assign watch_oh[w] = armed && (idx_q == IDX_W'(w));
      end
   endgenerate

   // R2: watched index frozen once armed
   p_hold_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> $stable(watch_idx));

   // R2: watched index always names a real way
   p_range_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> ({1'b0, watch_idx} < (IDX_W+1)'(WAYS)));

endmodule

// File: rtl/lru_used_flags.sv
module lru_used_flags #(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             armed,
   input  logic             acc_vld,
   input  logic [IDX_W-1:0] acc_idx,
   input  logic [WAYS-1:0]  watch_oh,
   output logic [WAYS-1:0]  used
);

   logic [WAYS-1:0] acc_dec;
   logic [WAYS-1:0] used_q;
   logic            watch_hit;

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         assign acc_dec[w] = acc_vld && (acc_idx == IDX_W'(w));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               used_q[w] <= 1'b0;
            end else if (armed) begin
               if (watch_hit) begin
                  used_q[w] <= 1'b0;
               end else if (acc_dec[w] && !watch_oh[w]) begin
                  used_q[w] <= 1'b1;
               end
            end
         end
      end
   endgenerate

   assign watch_hit = |(acc_dec & watch_oh);
   assign used      = used_q;

   // R5: touching the watched way empties every mark
   p_clear_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (armed && |(acc_dec & watch_oh)) |=> (used == '0));

   // R4: touching another way leaves its mark set
   p_set_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (armed && (acc_dec != '0) && !(|(acc_dec & watch_oh))) |=> |(used & $past(acc_dec)));

   // R4: the watched position is never marked
   p_own_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> !(|(used & watch_oh)));

   // R3: nothing is marked while arming
   p_arm_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> (used == '0));

endmodule

// File: rtl/lru_victim_judge.sv
module lru_victim_judge #(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             armed,
   input  logic             vic_vld,
   input  logic [IDX_W-1:0] vic_idx,
   input  logic [IDX_W-1:0] watch_idx,
   input  logic [WAYS-1:0]  watch_oh,
   input  logic [WAYS-1:0]  used,
   output logic             err
);

   logic covered;
   logic vic_on_watch;
   logic err_q;

   assign covered      = &(used | watch_oh);
   assign vic_on_watch = armed && vic_vld && (vic_idx == watch_idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else if (vic_on_watch && !covered) begin
         err_q <= 1'b1;
      end
   end

   assign err = err_q;

   // R6: early eviction of the watched way is reported
   p_flag_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (armed && vic_vld && (vic_idx == watch_idx) && !(&(used | watch_oh))) |=> err);

   // R9: error holds until reset
   p_sticky_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R3: the arming cycle cannot raise the error
   p_quiet_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> !err);

endmodule

// File: rtl/lru_victim_watch.sv
module lru_victim_watch
   import lru_watch_pkg::*;
#(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned IDX_W = idx_width(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] watch_sel,
   input  logic             acc_vld,
   input  logic [IDX_W-1:0] acc_idx,
   input  logic             vic_vld,
   input  logic [IDX_W-1:0] vic_idx,
   output logic             err
);

   generate
      if (WAYS < 2) begin : g_bad_ways
         $error("lru_victim_watch: WAYS must be at least 2");
      end
      if ((1 << IDX_W) < WAYS) begin : g_bad_width
         $error("lru_victim_watch: IDX_W too narrow for WAYS");
      end
   endgenerate

   logic             armed;
   logic [IDX_W-1:0] watch_idx;
   logic [WAYS-1:0]  watch_oh;
   logic [WAYS-1:0]  used;

   lru_watch_latch #(.WAYS(WAYS), .IDX_W(IDX_W)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (watch_sel),
      .armed     (armed),
      .watch_idx (watch_idx),
      .watch_oh  (watch_oh)
   );

   lru_used_flags #(.WAYS(WAYS), .IDX_W(IDX_W)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .armed    (armed),
      .acc_vld  (acc_vld),
      .acc_idx  (acc_idx),
      .watch_oh (watch_oh),
      .used     (used)
   );

   lru_victim_judge #(.WAYS(WAYS), .IDX_W(IDX_W)) u_judge (
      .clk       (clk),
      .rst_n     (rst_n),
      .armed     (armed),
      .vic_vld   (vic_vld),
      .vic_idx   (vic_idx),
      .watch_idx (watch_idx),
      .watch_oh  (watch_oh),
      .used      (used),
      .err       (err)
   );

   // R1: error is low in the first cycle after reset
   p_reset_r1 : assert property (@(posedge clk)
      !rst_n |=> !err);

endmodule

// File: tb/test_lru_victim_watch.sv
module test_lru_victim_watch;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] watch_sel = '0;
   logic       acc_vld = 1'b0;
   logic [1:0] acc_idx = '0;
   logic       vic_vld = 1'b0;
   logic [1:0] vic_idx = '0;
   logic       err4;
   logic       err3;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   lru_victim_watch #(.WAYS(4)) i_lru_victim_watch (
      .clk(clk), .rst_n(rst_n), .watch_sel(watch_sel),
      .acc_vld(acc_vld), .acc_idx(acc_idx),
      .vic_vld(vic_vld), .vic_idx(vic_idx), .err(err4)
   );

   lru_victim_watch #(.WAYS(3)) i_lru_victim_watch_3 (
      .clk(clk), .rst_n(rst_n), .watch_sel(watch_sel),
      .acc_vld(acc_vld), .acc_idx(acc_idx),
      .vic_vld(vic_vld), .vic_idx(vic_idx), .err(err3)
   );

   // arithmetic model of the marks, one slot per copy
   int unsigned nways [2] = '{4, 3};
   bit          m_arm [2];
   int unsigned m_w   [2];
   bit [3:0]    m_used[2];
   bit          m_err [2];

   task automatic model_edge();
      for (int k = 0; k < 2; k++) begin
         if (!rst_n) begin
            m_arm[k] = 0; m_w[k] = 0; m_used[k] = '0; m_err[k] = 0;
         end else if (!m_arm[k]) begin
            m_arm[k] = 1;
            m_w[k] = (watch_sel >= nways[k]) ? watch_sel - nways[k] : watch_sel;
         end else begin
            bit all_set = 1;
            for (int j = 0; j < int'(nways[k]); j++)
               if (j != int'(m_w[k]) && !m_used[k][j]) all_set = 0;
            if (vic_vld && vic_idx == m_w[k] && !all_set) m_err[k] = 1;
            if (acc_vld && acc_idx < nways[k]) begin
               if (acc_idx == m_w[k]) m_used[k] = '0;
               else m_used[k][acc_idx] = 1;
            end
         end
      end
   endtask

   task automatic check(string tag, string inst, bit act, bit exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: err=%0b expected %0b at %0t", tag, inst, act, exp, $time);
      end
   endtask

   task automatic check_both(string tag);
      check(tag, "ways4", err4, m_err[0]);
      check(tag, "ways3", err3, m_err[1]);
   endtask

   // one cycle of stimulus; called at a falling edge, returns at the next
   task automatic step(bit av, int ai, bit vv, int vi, string tag);
      acc_vld = av; acc_idx = 2'(ai);
      vic_vld = vv; vic_idx = 2'(vi);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      acc_vld = 0; vic_vld = 0;
      check_both(tag);
   endtask

   task automatic do_reset(int w);
      rst_n = 0;
      repeat (2) begin
         @(posedge clk);
         model_edge();
      end
      @(negedge clk);
      check_both("R1");
      rst_n = 1;
      watch_sel = 2'(w);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++; n_checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);

      // exhaustive: every watched way, every set of marked ways (R6, R7, R9, R10)
      for (int w = 0; w < 4; w++) begin
         for (int mask = 0; mask < 16; mask++) begin
            do_reset(w);
            step(0, 0, 0, 0, "R1");
            for (int j = 0; j < 4; j++)
               if (mask[j]) step(1, j, 0, 0, "R4");
            step(0, 0, 1, w, "R6_R7");
            step(1, w, 0, 0, "R9");
            step(0, 0, 0, 0, "R9");
         end
      end

      // R3: victim on watched way during arming is ignored
      do_reset(1);
      step(0, 0, 1, 1, "R3");
      step(1, 0, 0, 0, "R4");
      step(1, 2, 0, 0, "R4");
      step(1, 3, 0, 0, "R4");
      step(0, 0, 1, 1, "R7");
      step(0, 0, 1, 3, "R7");

      // R3: access during arming does not mark
      do_reset(1);
      step(1, 0, 0, 0, "R3");
      step(1, 2, 0, 0, "R4");
      step(1, 3, 0, 0, "R4");
      step(0, 0, 1, 1, "R3");

      // R5: clear after touching the watched way, then refill
      do_reset(2);
      step(0, 0, 0, 0, "R1");
      step(1, 0, 0, 0, "R4");
      step(1, 1, 0, 0, "R4");
      step(1, 3, 0, 0, "R4");
      step(1, 2, 0, 0, "R5");
      step(1, 0, 0, 0, "R4");
      step(1, 1, 0, 0, "R4");
      step(1, 3, 0, 0, "R4");
      step(0, 0, 1, 2, "R5");
      step(1, 2, 0, 0, "R5");
      step(0, 0, 1, 2, "R5");

      // R8: same-cycle victim and access judged against old marks
      do_reset(0);
      step(0, 0, 0, 0, "R1");
      step(1, 1, 0, 0, "R4");
      step(1, 2, 0, 0, "R4");
      step(1, 3, 1, 0, "R8");
      do_reset(0);
      step(0, 0, 0, 0, "R1");
      step(1, 1, 0, 0, "R4");
      step(1, 2, 0, 0, "R4");
      step(1, 3, 0, 0, "R4");
      step(1, 0, 1, 0, "R8");
      step(0, 0, 1, 0, "R8");

      // R2: folded select for three ways (select 3 watches way 0)
      do_reset(3);
      step(0, 0, 0, 0, "R2");
      watch_sel = 2'd1;
      step(1, 1, 0, 0, "R2");
      step(1, 2, 0, 0, "R2");
      step(0, 0, 1, 0, "R2");

      // pseudo-random run for every watched way
      for (int w = 0; w < 4; w++) begin
         logic [7:0] lf = 8'hA5 ^ 8'(w);
         do_reset(w);
         step(0, 0, 0, 0, "R1");
         for (int n = 0; n < 300; n++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            step(lf[0] | lf[1], int'(lf[3:2]), lf[4] & lf[5] & lf[6], int'(lf[7:6]), "R4_R6");
         end
      end

      // R9: reset clears a set error
      do_reset(0);
      step(0, 0, 0, 0, "R1");
      step(0, 0, 1, 0, "R6");
      do_reset(0);
      step(0, 0, 0, 0, "R9");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
   end

endmodule